// File: doc/BRIEF.md
# Register-Mapped Serial Port with Sticky Event Interrupt

This block is a byte-wide asynchronous serial port placed behind a small 32-bit register bus. Software writes one byte to the data register, and the transmitter sends it as a frame with one start bit, eight data bits LSB first and one stop bit. When a complete frame arrives on the receive pin, the receiver stores its byte in a one-entry holding register. Two sticky event flags record that a frame was sent or received. Software clears each flag by writing one to its bit. A single level interrupt combines each flag with its own enable bit.

There is no queue in either direction. The holding register keeps the first byte until software clears the receive event. A frame that completes before then is lost. A data write made while a frame is still going out is ignored. The bit time is the divisor times the oversampling factor in system clocks, and the receiver samples each bit at its middle. The serial pins carry the data stream, so the block has no valid/ready handshake. Back-pressure is expressed only by the transmit-empty status bit and the receive event flag. Every bus access is a full 32-bit word, and the register index comes from address bits [4:2].

Top module: `evuart`

## Requirements
- R1: After reset the data, divisor, control and debug registers read 0, the status register reads 0x1 (only bit 0, transmit-empty, set), irq is low and txd is high.
- R2: The divisor at offset 0x04 reads back the low 16 bits written to it. The control register at 0x0C reads back bits [2:0]. The debug register at 0x10 reads back bit 0. All other bits read 0. Offsets 0x14 to 0x1C read 0, and writes to them change nothing.
- R3: A write to offset 0x00 sends bits [7:0] on txd as one start bit (0), eight data bits LSB first and one stop bit (1). Each bit lasts 16*max(divisor,1) clocks, and txd idles high.
- R4: Status bit 0 is 0 from the data write until the stop bit ends. A data write made while a frame is being sent is ignored, and no second frame follows.
- R5: Status bit 2 (transmit event) sets only after the stop bit has been sent completely. It is still 0 during the stop bit.
- R6: The receiver samples the middle of each bit of a frame on rxd. Once the frame ends, offset 0x00 bits [7:0] hold the received byte and status bit 1 (receive event) is 1.
- R7: A frame that completes while status bit 1 is set is dropped. The stored byte and the flag keep their values.
- R8: A low pulse on rxd that no longer holds at the middle of the start bit does not produce a byte, and status bit 1 stays 0.
- R9: A write to status clears bit 1 and/or bit 2 where the written value has a one. Writing zeros has no effect, and bit 0 cannot be written.
- R10: irq = (control bit 0 AND status bit 1) OR (control bit 1 AND status bit 2). It reflects each register write in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The transmitter and the receiver are each run through all 256 byte values at divisor 1. A few values are repeated at divisor 3, which separates the bit timing from the framing and the bit order. A back-to-back data write shows whether the transmitter ignores a write while busy. A second frame received before the flag is cleared shows whether a late byte overwrites the holding register. Short low pulses at both divisors show whether false starts are rejected. The interrupt is checked over every combination of enable bits and events, including a clear of one flag while the other flag is still set.

// File: rtl/evuart_pkg.sv
package evuart_pkg;
  // register index taken from byte address bits [4:2]
  typedef enum logic [2:0] {
    RG_DATA = 3'd0,
    RG_DIV  = 3'd1,
    RG_STAT = 3'd2,
    RG_CTRL = 3'd3,
    RG_DBG  = 3'd4
  } reg_idx_e;

  localparam int ST_EMPTY = 0;
  localparam int ST_RXEV  = 1;
  localparam int ST_TXEV  = 2;

  localparam int CT_RXIE  = 0;
  localparam int CT_TXIE  = 1;
  localparam int CT_W     = 3;

  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/evuart_baud.sv
module evuart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  // divisor 0 behaves as divisor 1: a tick on every clock
  assign tick = (nxt >= {1'b0, div});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= nxt[DIV_W-1:0];
  end
endmodule

// File: rtl/evuart_tx.sv
module evuart_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       done,
  output logic       txd
);
  import evuart_pkg::*;
  localparam int SUB_W = $clog2(OVS);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [SUB_W-1:0]      sub;
  logic [BIT_W-1:0]      bitn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sh   <= '1;
      sub  <= '0;
      bitn <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= {1'b1, data, 1'b0};
          sub  <= '0;
          bitn <= '0;
        end
      end else if (tick) begin
        if (sub == SUB_W'(OVS - 1)) begin
          sub <= '0;
          if (bitn == BIT_W'(FRAME_BITS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {1'b1, sh[FRAME_BITS-1:1]};
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/evuart_rx.sv
module evuart_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data
);
  import evuart_pkg::*;
  localparam int SUB_W = $clog2(OVS);
  localparam int HALF  = OVS / 2 - 1;

  logic       s1, s2;
  rx_state_e  st;
  logic [SUB_W-1:0] sub;
  logic [2:0] bitn;
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      sub  <= '0;
      bitn <= '0;
      sh   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!s2) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: begin
            if (sub == SUB_W'(HALF)) begin
              sub  <= '0;
              bitn <= '0;
              st   <= s2 ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub == SUB_W'(OVS - 1)) begin
              sub <= '0;
              sh  <= {s2, sh[7:1]};
              if (bitn == 3'd7) st <= RX_STOP;
              else              bitn <= bitn + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub == SUB_W'(OVS - 1)) begin
              sub  <= '0;
              done <= 1'b1;
              st   <= RX_IDLE;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign data = sh;
endmodule

// File: rtl/evuart.sv
module evuart #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        txd,
  input  logic        rxd
);
  import evuart_pkg::*;

  reg_idx_e         idx;
  logic             wr, wr_data, wr_div, wr_stat, wr_ctrl, wr_dbg;
  logic [DIV_W-1:0] div_q;
  logic [CT_W-1:0]  ctrl_q;
  logic             dbg_q;
  logic             rx_evt, tx_evt;
  logic [7:0]       rx_buf;
  logic             tick, tx_busy, tx_done, rx_done;
  logic [7:0]       rx_byte;
  logic             clr_rx, clr_tx, rx_take;
  logic             unused_bits;

  assign idx     = reg_idx_e'(bus_addr[4:2]);
  assign wr      = bus_en & bus_wr;
  assign wr_data = wr && (idx == RG_DATA);
  assign wr_div  = wr && (idx == RG_DIV);
  assign wr_stat = wr && (idx == RG_STAT);
  assign wr_ctrl = wr && (idx == RG_CTRL);
  assign wr_dbg  = wr && (idx == RG_DBG);

  assign clr_rx  = wr_stat & bus_wdata[ST_RXEV];
  assign clr_tx  = wr_stat & bus_wdata[ST_TXEV];
  // a byte is taken when the holding register is free or freed this cycle
  assign rx_take = rx_done & (~rx_evt | clr_rx);

  assign unused_bits = ^bus_wdata ^ ^bus_addr[1:0];

  evuart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (div_q),
    .tick (tick)
  );

  evuart_tx #(.OVS(OVS)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .start(wr_data),
    .data (bus_wdata[7:0]),
    .busy (tx_busy),
    .done (tx_done),
    .txd  (txd)
  );

  evuart_rx #(.OVS(OVS)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .rxd  (rxd),
    .done (rx_done),
    .data (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
      dbg_q  <= 1'b0;
      rx_evt <= 1'b0;
      tx_evt <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_ctrl) ctrl_q <= bus_wdata[CT_W-1:0];
      if (wr_dbg)  dbg_q  <= bus_wdata[0];
      if (rx_take) rx_buf <= rx_byte;
      // a new event outranks a clear in the same cycle
      rx_evt <= rx_take | (rx_evt & ~clr_rx);
      tx_evt <= tx_done | (tx_evt & ~clr_tx);
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      RG_DATA: bus_rdata[7:0]       = rx_buf;
      RG_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      RG_STAT: bus_rdata[2:0]       = {tx_evt, rx_evt, ~tx_busy};
      RG_CTRL: bus_rdata[CT_W-1:0]  = ctrl_q;
      RG_DBG:  bus_rdata[0]         = dbg_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (ctrl_q[CT_RXIE] & rx_evt) | (ctrl_q[CT_TXIE] & tx_evt);
endmodule

// File: rtl/evuart_chk.sv
module evuart_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_wr,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        irq,
  input logic        tx_busy,
  input logic        tx_done,
  input logic        rx_done,
  input logic        rx_evt,
  input logic        tx_evt,
  input logic [7:0]  rx_buf
);
  logic w_data, w_stat, w_ctrl;
  assign w_data = bus_en && bus_wr && (bus_addr[4:2] == 3'd0);
  assign w_stat = bus_en && bus_wr && (bus_addr[4:2] == 3'd2);
  assign w_ctrl = bus_en && bus_wr && (bus_addr[4:2] == 3'd3);

  // R10
  ctrl_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && bus_wdata[1:0] == 2'b00) |=> !irq);

  // R9
  w1c_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && bus_wdata[2:1] == 2'b11 && !rx_done && !tx_done) |=> (!rx_evt && !tx_evt));

  // R4
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(w_data));

  // R5
  txev_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_evt) |-> $past(tx_done));

  // R6
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_evt);

  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_evt && !(w_stat && bus_wdata[1])) |=> ($stable(rx_buf) && rx_evt));
endmodule

bind evuart evuart_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .tx_busy  (tx_busy),
  .tx_done  (tx_done),
  .rx_done  (rx_done),
  .rx_evt   (rx_evt),
  .tx_evt   (tx_evt),
  .rx_buf   (rx_buf)
);

// File: tb/evuart_tb.sv
`timescale 1ns/1ps
module evuart_tb;
  localparam int CLK = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, txd;
  logic        rxd = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK/2) clk = ~clk;

  evuart u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // sends one byte and checks frame, empty bit and event timing
  task automatic tx_frame(input logic [7:0] b, input int div, input bit extra);
    time p, t_e;
    logic [31:0] d;
    logic [7:0] got;
    p = time'(16 * (div < 1 ? 1 : div) * CLK);
    wr(5'h00, {24'h0, b});
    t_e = $time - 1;
    rd(5'h08, d);
    chk("R4 empty low while sending", d[0], 1'b0);
    chk("R5 no event at start", d[2], 1'b0);
    if (extra) wr(5'h00, {24'h0, ~b});
    #(t_e + p/2 - $time);
    chk("R3 start bit", txd, 1'b0);
    for (int i = 0; i < 8; i++) begin
      #(p);
      got[i] = txd;
    end
    chk(extra ? "R4 busy write ignored" : "R3 data bits", got, b);
    #(p);
    chk("R3 stop bit", txd, 1'b1);
    rd(5'h08, d);
    chk("R5 no event during stop", d[2], 1'b0);
    #(t_e + 10*p + p/2 - $time);
    chk("R4 line idle after frame", txd, 1'b1);
    rd(5'h08, d);
    chk("R5 event and empty after stop", d[2:0], 3'b101);
    wr(5'h08, 32'h4);
  endtask

  task automatic rx_drive(input logic [7:0] b, input int div);
    time p;
    p = time'(16 * (div < 1 ? 1 : div) * CLK);
    @(negedge clk);
    rxd = 1'b0;
    #(p);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      #(p);
    end
    rxd = 1'b1;
    #(p);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(time'(CLK) * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(5'h00, d); chk("R1 data", d, 32'h0);
    rd(5'h04, d); chk("R1 divisor", d, 32'h0);
    rd(5'h08, d); chk("R1 status", d, 32'h1);
    rd(5'h0C, d); chk("R1 control", d, 32'h0);
    rd(5'h10, d); chk("R1 debug", d, 32'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 txd", txd, 1'b1);

    // R2 readback widths and unmapped offsets
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk("R2 divisor", d, 32'h0000_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); chk("R2 control", d, 32'h7);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); chk("R2 debug", d, 32'h1);
    for (int a = 5; a < 8; a++) begin
      wr(5'(a*4), 32'hFFFF_FFFF);
      rd(5'(a*4), d); chk("R2 unmapped reads zero", d, 32'h0);
    end
    rd(5'h04, d); chk("R2 divisor kept", d, 32'h0000_FFFF);
    wr(5'h04, 32'h1234_5678); rd(5'h04, d); chk("R2 divisor value", d, 32'h5678);
    wr(5'h0C, 32'h0); wr(5'h10, 32'h0);

    // R3 R4 R5 transmit sweep
    wr(5'h04, 32'h1);
    for (int v = 0; v < 256; v++) tx_frame(8'(v), 1, 1'b0);
    wr(5'h04, 32'h3);
    tx_frame(8'hA5, 3, 1'b0);
    tx_frame(8'h3C, 3, 1'b0);
    tx_frame(8'h00, 3, 1'b0);
    tx_frame(8'h81, 3, 1'b1);
    wr(5'h04, 32'h0);
    tx_frame(8'h5A, 0, 1'b1);
    wr(5'h04, 32'h1);
    tx_frame(8'hC3, 1, 1'b1);

    // R6 receive sweep
    for (int v = 0; v < 256; v++) begin
      rx_drive(8'(v), 1);
      rd(5'h00, d); chk("R6 received byte", d, {24'h0, 8'(v)});
      rd(5'h08, d); chk("R6 receive event", d[2:0], 3'b011);
      wr(5'h08, 32'h2);
    end
    wr(5'h04, 32'h3);
    rx_drive(8'h96, 3);
    rd(5'h00, d); chk("R6 byte at divisor 3", d, 32'h96);
    wr(5'h08, 32'h2);

    // R7 drop while flag set
    rx_drive(8'h4E, 3);
    rx_drive(8'hB1, 3);
    rd(5'h00, d); chk("R7 first byte kept", d, 32'h4E);
    rd(5'h08, d); chk("R7 flag kept", d[1], 1'b1);
    wr(5'h08, 32'h2);
    rx_drive(8'h27, 3);
    rd(5'h00, d); chk("R7 accepted after clear", d, 32'h27);
    wr(5'h08, 32'h2);

    // R8 false starts
    @(negedge clk); rxd = 1'b0;
    repeat (15) @(negedge clk); rxd = 1'b1;
    repeat (600) @(negedge clk);
    rd(5'h08, d); chk("R8 glitch at divisor 3", d[1], 1'b0);
    wr(5'h04, 32'h1);
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(5'h08, d); chk("R8 glitch at divisor 1", d[1], 1'b0);

    // R10 with R9: both events set
    wr(5'h0C, 32'h0);
    rx_drive(8'h11, 1);
    chk("R10 rx event masked", irq, 1'b0);
    wr(5'h0C, 32'h1); chk("R10 rx enabled", irq, 1'b1);
    wr(5'h0C, 32'h2); chk("R10 tx enable without tx event", irq, 1'b0);
    wr(5'h00, 32'h22);
    repeat (200) @(negedge clk);
    chk("R10 tx event enabled", irq, 1'b1);
    wr(5'h0C, 32'h0); chk("R10 both masked", irq, 1'b0);
    wr(5'h0C, 32'h3); chk("R10 both enabled", irq, 1'b1);
    wr(5'h08, 32'h0); rd(5'h08, d); chk("R9 write zero no effect", d, 32'h7);
    wr(5'h08, 32'h1); rd(5'h08, d); chk("R9 bit 0 not writable", d, 32'h7);
    wr(5'h08, 32'h2); rd(5'h08, d); chk("R9 clear rx only", d, 32'h5);
    chk("R10 tx event still raises", irq, 1'b1);
    wr(5'h08, 32'h4); rd(5'h08, d); chk("R9 clear tx", d, 32'h1);
    chk("R10 low after clears", irq, 1'b0);
    wr(5'h0C, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule